// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital control and status logic that sits around a 10-bit successive-approximation A/D converter. Software programs a small control/status register (CSR) to pick a channel and a mode, then sets a start bit. The sequencer runs the bit-trial loop against an external comparator, one bit per clock and most significant bit first. It writes each finished code into a result register for that channel and reports completion through a done flag and an interrupt request.

Single mode converts one channel once and then returns to idle, clearing the start bit. Scan mode visits channels 0 up to the selected channel in ascending order and wraps back to 0. It keeps doing so until software clears the start bit, and it raises the done flag after every full pass. The done flag clears through a read-then-write-zero handshake, or at once when a DMA acknowledge arrives.

Top module: `adc_seq_ctrl`

## Requirements
- R1: CSR layout: bit 0 start, bit 1 scan mode (0 single, 1 scan), bits 5:2 channel select (channel 1 is 0001), bit 6 interrupt enable, bit 7 done. After reset the CSR reads 0, every result register reads 0, `dac_o` is 0 and `irq_o` is 0.
- R2: The bit-trial loop yields a 10-bit code. Each clock it keeps the current trial bit when `cmp_i` is 1, which means the input is at or above `dac_o`. For an input code v the stored result is v, including 0 and 1023.
- R3: A CSR write with start=1 and scan=0 while idle converts the channel named in bits 5:2. The start bit reads 1 until the result is stored. The store happens on the 11th rising edge after the write edge (10 trial clocks and 1 store clock). On that same edge the done flag becomes 1 and the start bit returns to 0.
- R4: A single conversion changes only the result register of its own channel.
- R5: With start=1 and scan=1, channels 0..N are converted in ascending order, where N is the channel field, 11 clocks each. The sequence wraps to 0 after N. `conv_ch_o` shows the channel being converted. The start bit stays 1, and the done flag is set on the edge that stores channel N.
- R6: `irq_o` is 1 exactly when the done flag and the interrupt enable (bit 6) are both 1. The enable can be written at any time.
- R7: A CSR write with bit 7 = 0 clears the done flag only when a CSR read that returned done=1 came before it. Without such a read the flag stays 1.
- R8: A one-clock pulse on `dma_ack_i` clears the done flag.
- R9: A start write while a conversion is running is ignored. The running conversion keeps its channel, mode and completion edge, and the channel field is not changed.
- R10: A CSR write with bit 0 = 0 during scan mode clears the start bit on that edge. The conversion in progress runs to its end, but it stores no result and does not set the done flag. The block then becomes idle and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_wr_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 8 | CSR write data |
| csr_rd_i | input | 1 | CSR read strobe (arms the done clear) |
| csr_rdata_o | output | 8 | CSR read data |
| res_sel_i | input | 4 | Result register select |
| res_data_o | output | 10 | Selected result register |
| cmp_i | input | 1 | Comparator: input at or above `dac_o` |
| dac_o | output | 10 | Trial code for the DAC |
| conv_ch_o | output | 4 | Channel being converted |
| irq_o | output | 1 | Interrupt request |
| dma_ack_i | input | 1 | DMA acknowledge, clears done |

## Verification
A bit-trial register that drops or shifts a bit shows up as a wrong code at the store edge, 11 clocks after the start. The trial sequence on `dac_o` already diverges one clock after the bad step. A wrong channel pointer shows up on `conv_ch_o` in the very next clock, and as a result written into the wrong register. A done flag or a disarm latch stuck in the wrong state shows up through `irq_o` and CSR bit 7 on the clock after the read, write or acknowledge that should have changed it. The bench therefore samples these ports on the exact cycle where the change is due.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned DEF_RES_W = 10;
  localparam int unsigned DEF_NCH   = 16;

  typedef enum logic [1:0] {
    SAR_IDLE  = 2'd0,
    SAR_TRIAL = 2'd1,
    SAR_STORE = 2'd2
  } sar_state_e;
endpackage

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = DEF_RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic             busy_o,
  output logic             eoc_o
);
  localparam int unsigned IDX_W = $clog2(RES_W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  sar_state_e       state_q;
  logic [RES_W-1:0] acc_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SAR_IDLE;
      acc_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SAR_TRIAL: begin
          if (!cmp_i) acc_q[idx_q] <= 1'b0;
          if (idx_q == '0) begin
            state_q <= SAR_STORE;
          end else begin
            acc_q[idx_q - 1'b1] <= 1'b1;
            idx_q               <= idx_q - 1'b1;
          end
        end
        default: begin
          if (go_i) begin
            acc_q   <= {1'b1, {(RES_W-1){1'b0}}};
            idx_q   <= TOP_IDX;
            state_q <= SAR_TRIAL;
          end else begin
            state_q <= SAR_IDLE;
          end
        end
      endcase
    end
  end

  assign trial_o = acc_q;
  assign busy_o  = (state_q != SAR_IDLE);
  assign eoc_o   = (state_q == SAR_STORE);

  // trial counter kept for checking only
  logic [IDX_W:0] trial_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         trial_cnt_q <= '0;
    else if (go_i && state_q != SAR_TRIAL)               trial_cnt_q <= '0;
    else if (state_q == SAR_TRIAL)                       trial_cnt_q <= trial_cnt_q + 1'b1;
  end

  // R3
  store_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SAR_STORE) |-> (trial_cnt_q == (IDX_W+1)'(RES_W)));

  // R9
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (state_q != SAR_TRIAL));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = DEF_RES_W,
  parameter int unsigned NCH   = DEF_NCH,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wsel_i,
  input  logic [RES_W-1:0] wdata_i,
  input  logic [CH_W-1:0]  rsel_i,
  output logic [RES_W-1:0] rdata_o
);
  logic [RES_W-1:0] bank_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 bank_q[g] <= '0;
      else if (we_i && wsel_i == CH_W'(g))         bank_q[g] <= wdata_i;
    end
  end

  assign rdata_o = bank_q[rsel_i];
endmodule

// File: rtl/adc_done_flag.sv
module adc_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_zero_i,
  input  logic dma_ack_i,
  output logic done_o
);
  logic done_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      done_q  <= 1'b1;
    end else if (dma_ack_i || (clr_zero_i && armed_q)) begin
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (rd_i && done_q) begin
      armed_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  // R7
  done_clr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(dma_ack_i || clr_zero_i));

  // R8
  dma_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_i && !set_i) |=> !done_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W = DEF_RES_W,
  parameter int unsigned NCH   = DEF_NCH,
  localparam int unsigned CH_W  = $clog2(NCH),
  localparam int unsigned CSR_W = CH_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_wr_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  input  logic             csr_rd_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  input  logic [CH_W-1:0]  res_sel_i,
  output logic [RES_W-1:0] res_data_o,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [CH_W-1:0]  conv_ch_o,
  output logic             irq_o,
  input  logic             dma_ack_i
);
  localparam int unsigned P_START = 0;
  localparam int unsigned P_SCAN  = 1;
  localparam int unsigned P_CH_LO = 2;
  localparam int unsigned P_IE    = CH_W + 2;
  localparam int unsigned P_DONE  = CH_W + 3;

  logic            start_q, scan_q, ie_q;
  logic [CH_W-1:0] chsel_q, cur_ch_q;
  logic            core_busy, core_eoc, core_go, done;
  logic [CH_W-1:0] wr_ch;
  logic            launch, stop_req, store_en, next_go, last_ch, done_set;

  assign wr_ch    = csr_wdata_i[P_CH_LO +: CH_W];
  assign launch   = csr_wr_i && csr_wdata_i[P_START] && !start_q && !core_busy;
  assign stop_req = csr_wr_i && start_q && scan_q && !csr_wdata_i[P_START];
  assign last_ch  = (cur_ch_q == chsel_q);
  assign store_en = core_eoc && start_q;
  assign next_go  = store_en && scan_q && !stop_req;
  assign core_go  = launch || next_go;
  assign done_set = store_en && (!scan_q || last_ch);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= 1'b0;
      scan_q   <= 1'b0;
      ie_q     <= 1'b0;
      chsel_q  <= '0;
      cur_ch_q <= '0;
    end else begin
      if (csr_wr_i) ie_q <= csr_wdata_i[P_IE];
      // mode and channel only change while fully idle
      if (csr_wr_i && !start_q && !core_busy) begin
        scan_q  <= csr_wdata_i[P_SCAN];
        chsel_q <= wr_ch;
      end
      if (launch) begin
        start_q  <= 1'b1;
        cur_ch_q <= csr_wdata_i[P_SCAN] ? '0 : wr_ch;
      end else if (stop_req || (store_en && !scan_q)) begin
        start_q  <= 1'b0;
      end
      if (store_en && scan_q) cur_ch_q <= last_ch ? '0 : cur_ch_q + 1'b1;
    end
  end

  adc_sar_core #(.RES_W(RES_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (core_go),
    .cmp_i   (cmp_i),
    .trial_o (dac_o),
    .busy_o  (core_busy),
    .eoc_o   (core_eoc)
  );

  adc_result_bank #(.RES_W(RES_W), .NCH(NCH)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store_en),
    .wsel_i  (cur_ch_q),
    .wdata_i (dac_o),
    .rsel_i  (res_sel_i),
    .rdata_o (res_data_o)
  );

  adc_done_flag u_done (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (done_set),
    .rd_i       (csr_rd_i),
    .clr_zero_i (csr_wr_i && !csr_wdata_i[P_DONE]),
    .dma_ack_i  (dma_ack_i),
    .done_o     (done)
  );

  assign csr_rdata_o = {done, ie_q, chsel_q, scan_q, start_q};
  assign conv_ch_o   = cur_ch_q;
  assign irq_o       = done && ie_q;

  // R3
  start_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> $past(core_eoc || stop_req));

  // R5
  scan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && scan_q && core_eoc && !stop_req) |=> start_q);

  // R5
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done) |-> $past(core_eoc && start_q));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_wr = 1'b0, csr_rd = 1'b0, dma_ack = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] csr_rdata;
  logic [3:0] res_sel = '0;
  logic [9:0] res_data, dac;
  logic [3:0] conv_ch;
  logic       irq, cmp;
  logic [9:0] vin [16];

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int ch; int val; int due; string req; } exp_t;
  exp_t exp_q[$];
  exp_t mon_it;

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  assign cmp = (vin[conv_ch] >= dac);

  adc_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_wr_i(csr_wr), .csr_wdata_i(csr_wdata),
    .csr_rd_i(csr_rd), .csr_rdata_o(csr_rdata),
    .res_sel_i(res_sel), .res_data_o(res_data),
    .cmp_i(cmp), .dac_o(dac), .conv_ch_o(conv_ch),
    .irq_o(irq), .dma_ack_i(dma_ack)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic at_neg(input int n);
    do @(negedge clk); while (cyc < n);
  endtask

  task automatic csr_write(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(posedge clk); #1;
    csr_wr = 1'b0;
  endtask

  task automatic csr_read(output logic [7:0] v);
    csr_rd = 1'b1; #1 v = csr_rdata;
    @(posedge clk); #1;
    csr_rd = 1'b0;
  endtask

  task automatic dma_pulse();
    dma_ack = 1'b1;
    @(posedge clk); #1;
    dma_ack = 1'b0;
  endtask

  task automatic push(input int ch, input int val, input int due, input string req);
    exp_t e;
    e.ch = ch; e.val = val; e.due = due; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic read_res(input int ch, input int expv, input string req);
    @(negedge clk);
    res_sel = ch[3:0]; #1;
    chk(req, int'(res_data), expv);
  endtask

  // monitor: pops expected results on their due cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      mon_it = exp_q.pop_front();
      res_sel = mon_it.ch[3:0];
      #1;
      chk(mon_it.req, int'(res_data), mon_it.val);
      chk({mon_it.req, "_due"}, cyc, mon_it.due);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0;
    logic [7:0] rv;
    for (int i = 0; i < 16; i++) vin[i] = 10'd0;
    #20 rst_n = 1'b1;
    at_neg(2);
    // R1 reset state
    chk("R1_csr", int'(csr_rdata), 0);
    chk("R1_irq", int'(irq), 0);
    chk("R1_dac", int'(dac), 0);
    read_res(0, 0, "R1_res");

    // R3 single conversion, channel 1, ie=1
    vin[1] = 10'h2A5;
    @(negedge clk); csr_write(8'h45); c0 = cyc;
    push(1, 'h2A5, c0 + 11, "R2_ch1");
    at_neg(c0 + 10);
    chk("R3_start_busy", int'(csr_rdata[0]), 1);
    chk("R3_done_early", int'(csr_rdata[7]), 0);
    at_neg(c0 + 11);
    chk("R3_start_clr", int'(csr_rdata[0]), 0);
    chk("R3_done_set", int'(csr_rdata[7]), 1);
    chk("R6_irq_on", int'(irq), 1);
    at_neg(c0 + 13);
    read_res(0, 0, "R4_ch0_kept");

    // R7 zero write without read, then read + zero write
    @(negedge clk); csr_write(8'h40);
    chk("R7_no_read", int'(csr_rdata[7]), 1);
    @(negedge clk); csr_read(rv);
    chk("R7_read_sees", int'(rv[7]), 1);
    chk("R7_read_keeps", int'(csr_rdata[7]), 1);
    @(negedge clk); csr_write(8'h40);
    chk("R7_cleared", int'(csr_rdata[7]), 0);
    chk("R6_irq_off", int'(irq), 0);

    // R2 extreme codes
    vin[15] = 10'h3FF;
    @(negedge clk); csr_write(8'h3D); c0 = cyc;
    push(15, 'h3FF, c0 + 11, "R2_full");
    at_neg(c0 + 12);
    vin[2] = 10'h000;
    read_res(2, 0, "R4_pre");
    @(negedge clk); csr_write(8'h09); c0 = cyc;
    push(2, 0, c0 + 11, "R2_zero");
    at_neg(c0 + 12);
    read_res(15, 'h3FF, "R4_ch15_kept");

    // R9 start while running ignored
    vin[3] = 10'h155;
    @(negedge clk); csr_write(8'h0D); c0 = cyc;
    push(3, 'h155, c0 + 11, "R9_ch3");
    at_neg(c0 + 3);
    csr_write(8'h15);
    at_neg(c0 + 10);
    chk("R9_still_busy", int'(csr_rdata[0]), 1);
    at_neg(c0 + 11);
    chk("R9_chan_kept", int'(csr_rdata[5:2]), 3);
    chk("R9_ended", int'(csr_rdata[0]), 0);
    at_neg(c0 + 13);
    read_res(5, 0, "R9_ch5_untouched");

    // R8 DMA acknowledge
    chk("R8_pre", int'(csr_rdata[7]), 1);
    @(negedge clk); dma_pulse();
    chk("R8_dma_clr", int'(csr_rdata[7]), 0);

    // R6 enable gating
    vin[4] = 10'h0F0;
    @(negedge clk); csr_write(8'h11); c0 = cyc;
    push(4, 'h0F0, c0 + 11, "R2_ch4");
    at_neg(c0 + 11);
    chk("R6_done_no_ie", int'(csr_rdata[7]), 1);
    chk("R6_irq_masked", int'(irq), 0);
    @(negedge clk); csr_write(8'h40);
    chk("R6_irq_enabled", int'(irq), 1);
    @(negedge clk); dma_pulse();
    chk("R8_dma_irq", int'(irq), 0);

    // R5 scan channels 0..3
    vin[0] = 10'h011; vin[1] = 10'h222; vin[2] = 10'h333; vin[3] = 10'h044;
    @(negedge clk); csr_write(8'h4F); c0 = cyc;
    push(0, 'h011, c0 + 11, "R5_p1c0");
    push(1, 'h222, c0 + 22, "R5_p1c1");
    push(2, 'h333, c0 + 33, "R5_p1c2");
    push(3, 'h044, c0 + 44, "R5_p1c3");
    push(0, 'h1C7, c0 + 55, "R5_p2c0");
    at_neg(c0 + 1);
    chk("R5_ch_first", int'(conv_ch), 0);
    at_neg(c0 + 12);
    chk("R5_ch_next", int'(conv_ch), 1);
    at_neg(c0 + 20);
    vin[0] = 10'h1C7;
    at_neg(c0 + 33);
    chk("R5_ch_last", int'(conv_ch), 3);
    chk("R5_done_mid", int'(csr_rdata[7]), 0);
    at_neg(c0 + 44);
    chk("R5_done_pass", int'(csr_rdata[7]), 1);
    chk("R5_start_held", int'(csr_rdata[0]), 1);
    chk("R5_wrap", int'(conv_ch), 0);
    at_neg(c0 + 46);
    dma_pulse();

    // R10 stop scan mid conversion of channel 1
    at_neg(c0 + 55);
    vin[1] = 10'h0AB;
    at_neg(c0 + 59);
    csr_write(8'h4C);
    chk("R10_start_clr", int'(csr_rdata[0]), 0);
    at_neg(c0 + 70);
    chk("R10_no_done", int'(csr_rdata[7]), 0);
    read_res(1, 'h222, "R10_no_store");
    at_neg(c0 + 75);
    csr_write(8'h45); c0 = cyc;
    push(1, 'h0AB, c0 + 11, "R10_restart");
    at_neg(c0 + 12);
    chk("R10_done_after", int'(csr_rdata[7]), 1);

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule